// File: doc/BRIEF.md
# Dual-Source Reset Delay Generator

This block builds a system reset from two asynchronous requests: a supply-good flag, which an external comparator drives high while the supply is healthy, and an active-low manual reset request. Each request passes through its own synchronizer. Reset asserts as soon as either synchronized request goes active. It is released only after both requests have stayed inactive for a fixed number of clock-enable ticks.

A single delay counter drives two outputs: an active-low reset and an active-high reset. These two are always exact complements. The tick input is a clock-enable pulse. The delay parameter is chosen for the nominal release time at the tick rate in use. For example, 200 ticks at 1 kHz gives 200 ms, which sits inside the allowed 140 ms to 280 ms window. If a request becomes active again during the delay, even for one cycle, the count restarts from zero.

Top module: `rst_delay_gen`

## Requirements
- R1: While the block's own reset `rst` is high, and right after it, both outputs show reset asserted and the delay count is zero. With both requests inactive, the first release therefore needs the full delay.
- R2: A low level on `supply_ok_i` asserts reset two clock edges later (synchronizer latency). Reset then stays asserted for as long as the flag stays low.
- R3: A low level on `man_rst_n_i` asserts reset two clock edges later. Reset then stays asserted for as long as the request stays low.
- R4: Suppose `tick_i` is high on every cycle and both requests go inactive before clock edge k. Then reset deasserts after edge k+DELAY_TICKS+1. More generally, the release happens on the DELAY_TICKS-th tick that follows the synchronized inactivity.
- R5: If either request goes active during the delay, the count is cleared. The full delay is then counted again from the last release of the requests.
- R6: A manual request that is low for a single clock cycle is captured, asserts reset, and restarts the full delay.
- R7: `sys_rst_n_o` is the exact complement of `sys_rst_o` on every cycle.
- R8: Once released, reset stays deasserted for as long as both requests stay inactive, however many ticks arrive.
- R9: The assert path does not wait for a tick or for the counter. Reset is asserted in the same cycle in which a synchronized request shows active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| tick_i | input | 1 | Clock-enable tick that paces the release delay |
| supply_ok_i | input | 1 | Asynchronous supply-good flag, high when the supply is healthy |
| man_rst_n_i | input | 1 | Asynchronous manual reset request, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The hardest case to reach from the ports is a request that comes back for one short cycle late in the delay, when the counter is close to its end. The bench creates this directly: it releases both requests, waits several ticks, then pulses the supply flag low for one cycle. It measures the release time from the end of that pulse. Random stimulus adds one-to-three-cycle manual pulses and sparse supply drops at random tick phases. This builds up many restarts at varied counter values, and each one is compared against a cycle-level reference model.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  // Index of each request inside the synchronizer bus
  localparam int unsigned IDX_SUPPLY = 0;
  localparam int unsigned IDX_MANUAL = 1;
  localparam int unsigned NUM_SRC    = 2;

  typedef enum logic [1:0] {
    PH_HOLD    = 2'd0,
    PH_COUNT   = 2'd1,
    PH_RELEASE = 2'd2
  } rdg_phase_e;
endpackage

// File: rtl/rdg_sync.sv
module rdg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R2 R3: output follows the previous stage one edge later
  p_sync_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q_o == $past(stage_q[STAGES-1 > 0 ? STAGES-2 : 0]) || STAGES == 1);
endmodule

// File: rtl/rdg_release_cnt.sv
module rdg_release_cnt
  import rdg_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic src_act_i,
  output logic done_o,
  output rdg_phase_e phase_o
);
  localparam int unsigned CW   = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || src_act_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q && tick_i) begin
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  always_comb begin
    if (src_act_i)   phase_o = PH_HOLD;
    else if (done_q) phase_o = PH_RELEASE;
    else             phase_o = PH_COUNT;
  end

  // R5: an active request clears the count on the next edge
  p_clear_on_src_r5: assert property (@(posedge clk) disable iff (rst)
    src_act_i |=> (cnt_q == '0) && !done_q);
  // R8: release is kept while requests stay inactive
  p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !src_act_i) |=> done_q);
  // R4: release only happens on a tick
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(tick_i));
  // R4: count never passes its last value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/rst_delay_gen.sv
module rst_delay_gen
  import rdg_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);
  logic [NUM_SRC-1:0] raw_bus;
  logic [NUM_SRC-1:0] sync_bus;
  logic               src_act;
  logic               done;
  rdg_phase_e         phase;

  assign raw_bus[IDX_SUPPLY] = supply_ok_i;
  assign raw_bus[IDX_MANUAL] = man_rst_n_i;

  // Synchronizers reset to the "request active" level
  rdg_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_bus),
    .q_o (sync_bus)
  );

  // Both requests are "good high"; any low bit is an active request
  assign src_act = ~&sync_bus;

  rdg_release_cnt #(
    .DELAY_TICKS(DELAY_TICKS)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .src_act_i(src_act),
    .done_o   (done),
    .phase_o  (phase)
  );

  assign sys_rst_o   = (phase != PH_RELEASE);
  assign sys_rst_n_o = ~sys_rst_o;

  // R9: an active synchronized request shows on the output at once
  p_assert_now_r9: assert property (@(posedge clk) disable iff (rst)
    src_act |-> sys_rst_o);
  // R1: reset of the block leaves reset asserted
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> sys_rst_o && !done);
endmodule

// File: tb/rst_delay_gen_tb_top.sv
module rst_delay_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sup = 1'b0;
  logic man = 1'b0;
  logic rst_n_o, rst_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_delay_gen #(.DELAY_TICKS(DLY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick),
    .supply_ok_i(sup), .man_rst_n_i(man),
    .sys_rst_n_o(rst_n_o), .sys_rst_o(rst_o));

  // Reference model built from the requirements
  logic [1:0] m_sup = 2'b00, m_man = 2'b00;
  int m_cnt = 0;
  bit m_done = 1'b0;

  function automatic bit exp_rst(bit [1:0] s, bit [1:0] m, bit d);
    return !s[1] || !m[1] || !d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sup <= 2'b00; m_man <= 2'b00; m_cnt <= 0; m_done <= 1'b0;
    end else begin
      m_sup <= {m_sup[0], sup};
      m_man <= {m_man[0], man};
      if (!m_sup[1] || !m_man[1]) begin
        m_cnt <= 0; m_done <= 1'b0;
      end else if (!m_done && tick) begin
        if (m_cnt == DLY-1) m_done <= 1'b1;
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(string req, bit act, bit expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(tag, rst_o, exp_rst(m_sup, m_man, m_done));
    chk("R7", rst_n_o, ~rst_o);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count edges until release; returns count
  task automatic wait_release(output int n);
    n = 0;
    while (rst_o && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    // R1: under reset
    sup = 1'b1; man = 1'b1; tick = 1'b1;
    step(3);
    chk("R1", rst_o, 1'b1);
    rst = 1'b0;
    // R1 + R4: release after full delay from block reset (sync refill)
    tag = "R4";
    wait_release(n);
    chk("R1", n == DLY + 2, 1'b1);
    // R8: held released with ticks running
    tag = "R8";
    step(40);
    chk("R8", rst_o, 1'b0);
    // R2: supply low asserts after two edges and holds
    tag = "R2";
    @(negedge clk); sup = 1'b0;
    step(1); chk("R9", rst_o, 1'b0);
    step(1); chk("R2", rst_o, 1'b1);
    step(30); chk("R2", rst_o, 1'b1);
    sup = 1'b1;
    wait_release(n);
    chk("R4", n == DLY + 2, 1'b1);
    // R3: manual hold
    tag = "R3";
    man = 1'b0; step(2); chk("R3", rst_o, 1'b1);
    step(25); chk("R3", rst_o, 1'b1);
    man = 1'b1;
    // R5: restart late in delay by a one-cycle supply drop
    tag = "R5";
    step(DLY - 1);
    sup = 1'b0; step(1); sup = 1'b1;
    wait_release(n);
    chk("R5", n == DLY + 2, 1'b1);
    // R6: single-cycle manual pulse after release
    tag = "R6";
    step(5);
    man = 1'b0; step(1); man = 1'b1;
    step(1); chk("R6", rst_o, 1'b1);
    wait_release(n);
    chk("R6", n == DLY + 1, 1'b1);
    // R4: sparse ticks (every third cycle)
    tag = "R4";
    sup = 1'b0; step(4); sup = 1'b1;
    for (int i = 0; i < 3 * DLY + 10; i++) begin
      tick = (i % 3 == 0); @(negedge clk);
    end
    chk("R4", rst_o, 1'b0);
    // Random mix
    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      tick = $urandom_range(1, 0);
      if ($urandom_range(99, 0) == 0) sup = ~sup;
      if (!sup && $urandom_range(3, 0) == 0) sup = 1'b1;
      if ($urandom_range(79, 0) == 0) man = 1'b0;
      else if (!man && $urandom_range(2, 0) == 0) man = 1'b1;
      @(negedge clk);
    end
    // R1: block reset mid-release reasserts
    tag = "R1";
    sup = 1'b1; man = 1'b1; tick = 1'b1;
    step(DLY + 5);
    rst = 1'b1; step(1); chk("R1", rst_o, 1'b1);
    rst = 1'b0;
    step(DLY + 5);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule